// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

This block produces the control-store address for a microprogrammed processor whose control store holds up to 4096 words. It keeps a 12-bit program counter and a 15-entry return-address stack. In every cycle it takes the decoded sequencing field of the control word now being read and picks where the next word comes from. The choices are the following word, an absolute target, a relative branch gated by a chosen condition flag, a subroutine call, a subroutine return, or a dispatch that adds a bus value to the current address.

The program counter is the control-store address. The control word read at `cs_addr` arrives back on the sequencing inputs in the same cycle, and the next address is registered at the following clock edge. The condition flags come from the data operation of the previous instruction, which runs in parallel. This gives one instruction per cycle. Misuse of the stack sets a sticky error output, and the faulting operation falls through to the next word.

Top module: `ucode_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `cs_addr` becomes 0, `stk_err` becomes 0 and the return stack is emptied.
- R2: `seq_op` 0 (next), and the unused codes 6 and 7, load `cs_addr + 1` modulo 4096, so 0xFFF is followed by 0x000.
- R3: `seq_op` 1 (jump) loads `target` as the next address.
- R4: `seq_op` 2 (branch) with a true condition loads `cs_addr` plus `target[10:0]` sign-extended, modulo 4096. Bit 10 is the sign.
- R5: The condition is selected by `cond_sel`: 0 always, 1 `cond_flags[0]` (carry), 2 `cond_flags[1]` (overflow), 3 `cond_flags[2]` (zero), 4 `cond_flags[3]` (negative), 5 `cond_flags[4]` (interrupt), 6 `cond_flags[5]` (macro condition), 7 never. When the branch is not taken, the next address is `cs_addr + 1`.
- R6: `seq_op` 3 (call) on a stack that is not full pushes `cs_addr + 1` and loads `target`.
- R7: `seq_op` 4 (return) on a stack that is not empty pops the most recently pushed address into the PC (last in, first out).
- R8: Fifteen nested calls succeed without raising `stk_err`.
- R9: A call made while 15 entries are held sets `stk_err`, leaves the stack contents unchanged and advances to `cs_addr + 1`.
- R10: A return on an empty stack sets `stk_err` and advances to `cs_addr + 1`.
- R11: Once set, `stk_err` stays high until reset.
- R12: `seq_op` 5 (dispatch/skip) loads `cs_addr + bus_val[11:0]` modulo 4096. Bits 15:12 of `bus_val` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_op | input | 3 | Sequencing operation of the current control word |
| cond_sel | input | 3 | Branch condition selector |
| target | input | 12 | Absolute target; the low 11 bits are the branch offset |
| cond_flags | input | 6 | Condition flags from the previous data operation |
| bus_val | input | 16 | Bus value for dispatch |
| cs_addr | output | 12 | Control-store address (the program counter) |
| stk_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The properties assume that the sequencing inputs are stable and known at every rising edge while reset is low. They also assume that each `seq_op` value maps to exactly one sequencing action. The stimulus changes the inputs only on falling edges and keeps every field driven with a defined value. Once reset is released, it holds reset high only through whole cycles, so no property sees a half-applied reset. The overflow and underflow properties observe the stack's full and empty state inside the block. The bench drives the stack past both limits only through calls and returns.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        OP_NEXT     = 3'd0,
        OP_JUMP     = 3'd1,
        OP_BRANCH   = 3'd2,
        OP_CALL     = 3'd3,
        OP_RETURN   = 3'd4,
        OP_DISPATCH = 3'd5
    } seq_op_e;

    typedef enum logic [2:0] {
        CS_ALWAYS = 3'd0,
        CS_CARRY  = 3'd1,
        CS_OVF    = 3'd2,
        CS_ZERO   = 3'd3,
        CS_NEG    = 3'd4,
        CS_IRQ    = 3'd5,
        CS_MACRO  = 3'd6,
        CS_NEVER  = 3'd7
    } cond_sel_e;

    localparam int FLAG_W = 6;

    // stack request produced by next-address logic
    typedef struct packed {
        logic push;
        logic pop;
        logic fault;
    } stk_ctl_t;

    function automatic logic cond_pick(cond_sel_e sel, logic [FLAG_W-1:0] f);
        logic r;
        case (sel)
            CS_ALWAYS: r = 1'b1;
            CS_CARRY:  r = f[0];
            CS_OVF:    r = f[1];
            CS_ZERO:   r = f[2];
            CS_NEG:    r = f[3];
            CS_IRQ:    r = f[4];
            CS_MACRO:  r = f[5];
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/seq_cond_mux.sv
module seq_cond_mux
    import seq_pkg::*;
(
    input  logic [2:0]        cond_sel,
    input  logic [FLAG_W-1:0] cond_flags,
    output logic              cond_true
);
    always_comb begin
        cond_true = cond_pick(cond_sel_e'(cond_sel), cond_flags);
    end
endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
    parameter int AW    = 12,
    parameter int DEPTH = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_addr,
    output logic [AW-1:0] top_addr,
    output logic          full,
    output logic          empty
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt_q;
    logic [AW-1:0] mem [DEPTH];

    // one write port per slot, selected by the fill count
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && int'(cnt_q) == i) begin
                mem[i] <= push_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        top_addr = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(cnt_q) == i + 1) begin
                top_addr = mem[i];
            end
        end
    end

    assign full  = (int'(cnt_q) == DEPTH);
    assign empty = (cnt_q == '0);
endmodule

// File: rtl/seq_next_addr.sv
module seq_next_addr
    import seq_pkg::*;
#(
    parameter int AW    = 12,
    parameter int BUS_W = 16,
    parameter int OFF_W = 11
) (
    input  seq_op_e          op,
    input  logic [AW-1:0]    pc,
    input  logic [AW-1:0]    target,
    input  logic             cond_true,
    input  logic [BUS_W-1:0] bus_val,
    input  logic [AW-1:0]    stk_top,
    input  logic             stk_full,
    input  logic             stk_empty,
    output logic [AW-1:0]    nxt,
    output logic [AW-1:0]    ret_addr,
    output stk_ctl_t         ctl
);
    localparam int EXT_W = AW - OFF_W;

    logic [AW-1:0] inc;
    logic [AW-1:0] rel;

    assign inc      = pc + 1'b1;
    assign rel      = {{EXT_W{target[OFF_W-1]}}, target[OFF_W-1:0]};
    assign ret_addr = inc;

    always_comb begin
        nxt = inc;
        ctl = '0;
        case (op)
            OP_JUMP:     nxt = target;
            OP_BRANCH:   if (cond_true) nxt = pc + rel;
            OP_CALL: begin
                if (stk_full) begin
                    ctl.fault = 1'b1;
                end else begin
                    ctl.push = 1'b1;
                    nxt      = target;
                end
            end
            OP_RETURN: begin
                if (stk_empty) begin
                    ctl.fault = 1'b1;
                end else begin
                    ctl.pop = 1'b1;
                    nxt     = stk_top;
                end
            end
            OP_DISPATCH: nxt = pc + bus_val[AW-1:0];
            default:     nxt = inc;
        endcase
    end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
    import seq_pkg::*;
#(
    parameter int AW    = 12,
    parameter int DEPTH = 15,
    parameter int BUS_W = 16,
    parameter int OFF_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        seq_op,
    input  logic [2:0]        cond_sel,
    input  logic [AW-1:0]     target,
    input  logic [FLAG_W-1:0] cond_flags,
    input  logic [BUS_W-1:0]  bus_val,
    output logic [AW-1:0]     cs_addr,
    output logic              stk_err
);
    logic [AW-1:0] pc_q;
    logic [AW-1:0] nxt_pc;
    logic [AW-1:0] ret_addr;
    logic [AW-1:0] stk_top;
    logic          stk_full;
    logic          stk_empty;
    logic          cond_true;
    logic          err_q;
    stk_ctl_t      stk_ctl;

    seq_cond_mux u_cond (
        .cond_sel  (cond_sel),
        .cond_flags(cond_flags),
        .cond_true (cond_true)
    );

    seq_next_addr #(.AW(AW), .BUS_W(BUS_W), .OFF_W(OFF_W)) u_nxt (
        .op       (seq_op_e'(seq_op)),
        .pc       (pc_q),
        .target   (target),
        .cond_true(cond_true),
        .bus_val  (bus_val),
        .stk_top  (stk_top),
        .stk_full (stk_full),
        .stk_empty(stk_empty),
        .nxt      (nxt_pc),
        .ret_addr (ret_addr),
        .ctl      (stk_ctl)
    );

    seq_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
        .clk      (clk),
        .rst      (rst),
        .push     (stk_ctl.push),
        .pop      (stk_ctl.pop),
        .push_addr(ret_addr),
        .top_addr (stk_top),
        .full     (stk_full),
        .empty    (stk_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            err_q <= 1'b0;
        end else begin
            pc_q  <= nxt_pc;
            err_q <= err_q | stk_ctl.fault;
        end
    end

    assign cs_addr = pc_q;
    assign stk_err = err_q;
endmodule

// File: rtl/ucode_seq_chk.sv
module ucode_seq_chk
    import seq_pkg::*;
#(
    parameter int AW    = 12,
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       seq_op,
    input logic [2:0]       cond_sel,
    input logic [AW-1:0]    target,
    input logic [BUS_W-1:0] bus_val,
    input logic [AW-1:0]    cs_addr,
    input logic             stk_err,
    input logic             stk_full,
    input logic             stk_empty
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (cs_addr == '0 && !stk_err));

    p_next_r2: assert property (@(posedge clk) disable iff (rst)
        (seq_op == OP_NEXT) |=> (cs_addr == AW'($past(cs_addr) + 1'b1)));

    p_jump_r3: assert property (@(posedge clk) disable iff (rst)
        (seq_op == OP_JUMP) |=> (cs_addr == $past(target)));

    p_never_r5: assert property (@(posedge clk) disable iff (rst)
        (seq_op == OP_BRANCH && cond_sel == CS_NEVER)
        |=> (cs_addr == AW'($past(cs_addr) + 1'b1)));

    p_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (seq_op == OP_CALL && stk_full)
        |=> (stk_err && cs_addr == AW'($past(cs_addr) + 1'b1)));

    p_underflow_r10: assert property (@(posedge clk) disable iff (rst)
        (seq_op == OP_RETURN && stk_empty)
        |=> (stk_err && cs_addr == AW'($past(cs_addr) + 1'b1)));

    p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        stk_err |=> stk_err);

    p_dispatch_r12: assert property (@(posedge clk) disable iff (rst)
        (seq_op == OP_DISPATCH)
        |=> (cs_addr == AW'($past(cs_addr) + $past(bus_val[AW-1:0]))));

    p_not_both_r9: assert property (@(posedge clk) disable iff (rst)
        !(stk_full && stk_empty));
endmodule

bind ucode_seq ucode_seq_chk #(.AW(AW), .BUS_W(BUS_W)) u_chk (.*);

// File: tb/ucode_seq_test.sv
module ucode_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  seq_op = 3'd0;
    logic [2:0]  cond_sel = 3'd0;
    logic [11:0] target = 12'h000;
    logic [5:0]  cond_flags = 6'h00;
    logic [15:0] bus_val = 16'h0000;
    logic [11:0] cs_addr;
    logic        stk_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ucode_seq uut (
        .clk(clk), .rst(rst), .seq_op(seq_op), .cond_sel(cond_sel),
        .target(target), .cond_flags(cond_flags), .bus_val(bus_val),
        .cs_addr(cs_addr), .stk_err(stk_err)
    );

    // {op, cond_sel, flags, target, bus, expected address}, walked from reset
    localparam int NV = 19;
    localparam logic [51:0] VEC [NV] = '{
        {3'd0, 3'd0, 6'h00, 12'h000, 16'h0000, 12'h001},  // R2
        {3'd0, 3'd0, 6'h00, 12'h000, 16'h0000, 12'h002},  // R2
        {3'd1, 3'd0, 6'h00, 12'h100, 16'h0000, 12'h100},  // R3
        {3'd2, 3'd0, 6'h00, 12'h010, 16'h0000, 12'h110},  // R4 always
        {3'd2, 3'd1, 6'h00, 12'h010, 16'h0000, 12'h111},  // R5 carry clear
        {3'd2, 3'd1, 6'h01, 12'h7F0, 16'h0000, 12'h101},  // R4 backward
        {3'd2, 3'd3, 6'h04, 12'h005, 16'h0000, 12'h106},  // R4 zero
        {3'd2, 3'd7, 6'h3F, 12'h020, 16'h0000, 12'h107},  // R5 never
        {3'd2, 3'd5, 6'h10, 12'h400, 16'h0000, 12'hD07},  // R4 irq, wrap
        {3'd5, 3'd0, 6'h00, 12'h000, 16'hF003, 12'hD0A},  // R12
        {3'd3, 3'd0, 6'h00, 12'h200, 16'h0000, 12'h200},  // R6
        {3'd2, 3'd2, 6'h02, 12'h001, 16'h0000, 12'h201},  // R4 overflow
        {3'd4, 3'd0, 6'h00, 12'h000, 16'h0000, 12'hD0B},  // R7
        {3'd2, 3'd6, 6'h20, 12'h003, 16'h0000, 12'hD0E},  // R4 macro
        {3'd2, 3'd4, 6'h37, 12'h001, 16'h0000, 12'hD0F},  // R5 negative clear
        {3'd1, 3'd0, 6'h00, 12'hFFF, 16'h0000, 12'hFFF},  // R3
        {3'd0, 3'd0, 6'h00, 12'h000, 16'h0000, 12'h000},  // R2 wrap
        {3'd5, 3'd0, 6'h00, 12'h000, 16'h0FFF, 12'hFFF},  // R12
        {3'd6, 3'd0, 6'h00, 12'h000, 16'h0000, 12'h000}   // R2 unused code
    };
    localparam int VREQ [NV] = '{2, 2, 3, 4, 5, 4, 4, 5, 4, 12, 6, 4, 7, 4, 5, 3, 2, 12, 2};

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    // called on a falling edge; returns on the next falling edge
    task automatic drive(input logic [2:0] op, input logic [2:0] cs, input logic [5:0] fl,
                         input logic [11:0] tg, input logic [15:0] bv);
        seq_op = op; cond_sel = cs; cond_flags = fl; target = tg; bus_val = bv;
        @(negedge clk);
    endtask

    task automatic do_reset();
        seq_op = 3'd0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 addr", cs_addr, 0);
        check("R1 err", stk_err, 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][51:49], VEC[i][48:46], VEC[i][45:40], VEC[i][39:28], VEC[i][27:12]);
            check($sformatf("R%0d vec%0d", VREQ[i], i), cs_addr, int'(VEC[i][11:0]));
        end
        check("R6 no error in table", stk_err, 0);

        // R10 and R11: underflow right after reset, then stickiness
        do_reset();
        check("R1 addr after reset", cs_addr, 0);
        drive(3'd4, 3'd0, 6'h00, 12'h000, 16'h0000);
        check("R10 addr", cs_addr, 1);
        check("R10 err", stk_err, 1);
        for (int i = 0; i < 3; i++) drive(3'd0, 3'd0, 6'h00, 12'h000, 16'h0000);
        check("R11 err held", stk_err, 1);
        check("R11 addr", cs_addr, 4);
        do_reset();
        check("R1 err cleared", stk_err, 0);

        // R8, R6: fifteen nested calls
        for (int k = 1; k <= 15; k++) begin
            drive(3'd3, 3'd0, 6'h00, 12'(k * 16), 16'h0000);
            check("R6 call target", cs_addr, k * 16);
        end
        check("R8 depth 15 ok", stk_err, 0);
        // R9: sixteenth call refused
        drive(3'd3, 3'd0, 6'h00, 12'h800, 16'h0000);
        check("R9 addr", cs_addr, 241);
        check("R9 err", stk_err, 1);
        // R7, R9: contents intact, LIFO order
        for (int j = 1; j <= 15; j++) begin
            drive(3'd4, 3'd0, 6'h00, 12'h000, 16'h0000);
            check("R7 return", cs_addr, (15 - j) * 16 + 1);
        end
        drive(3'd4, 3'd0, 6'h00, 12'h000, 16'h0000);
        check("R10 underflow after drain", cs_addr, 2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule